// File: doc/BRIEF.md
# Receive Flow-Control Threshold Unit

This block sits beside a UART receive FIFO and decides when the remote sender should be told to pause and when it may continue. It watches the FIFO occupancy count and compares it against two programmable levels, one to stop the sender and one to let it go again. The result drives an RTS-style ready line, which is high when the sender may transmit. Between the two levels the line keeps its previous state, so it does not chatter.

The unit also watches each received byte. When detection is on and a byte equals a programmed match character, it raises a sticky interrupt flag. The byte itself still goes to the FIFO, because that path is not handled here. The flag stays set until a one-cycle clear strobe drops it.

Software configures the unit through a small write-only port with three addresses: a control word, the packed level byte and the match character. The level byte can only be changed while two separate unlock bits in the control word are both set.

Top module: `rx_pace_unit`

## Requirements
- R1: Reset values: `rts_ready` is 1 and `spc_irq` is 0. The control word, the level byte and the match character are all 0, so automatic pacing and match detection are both off.
- R2: A write with `wr_addr`=1 (level byte) takes effect only when control bit 0 (feature unlock) and control bit 1 (level unlock) are both 1. Any other such write leaves the level byte unchanged. `wr_addr`=0 writes `wr_data[3:0]` to the control word. `wr_addr`=2 writes the match character. `wr_addr`=3 is ignored.
- R3: When control bit 2 (automatic pacing) is 0, `rts_ready` is 1 in the cycle after every edge, whatever the fill count.
- R4: When automatic pacing is on and `fill_cnt` is greater than or equal to the stop level, `rts_ready` is 0 after the next edge.
- R5: When automatic pacing is on and `fill_cnt` is below the stop level and less than or equal to the go level, `rts_ready` is 1 after the next edge.
- R6: When automatic pacing is on and `fill_cnt` lies strictly between the go level and the stop level, `rts_ready` keeps its previous value.
- R7: The hardware does not require the stop level to exceed the go level. When both conditions hold, the stop condition wins and `rts_ready` goes to 0.
- R8: When control bit 3 (match detect) is 1, a cycle with `rx_valid`=1 and `rx_byte` equal to the match character sets `spc_irq` after the next edge. A non-matching byte does not set it, and neither does any byte while detection is off.
- R9: `spc_irq` stays set until a cycle with `spc_clr`=1 clears it. If a match and `spc_clr` occur in the same cycle, the flag stays set.
- R10: In the level byte, bits [3:0] hold the stop field and bits [7:4] hold the go field. Each level in bytes is its field times 4, which gives 0 to 60. `fill_cnt` covers 0 to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration address: 0 control, 1 level byte, 2 match character |
| wr_data | input | 8 | Configuration write data |
| fill_cnt | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| spc_clr | input | 1 | One-cycle clear of the match flag |
| rts_ready | output | 1 | 1 = sender may transmit, 0 = sender must pause |
| spc_irq | output | 1 | Sticky match-character interrupt flag |

## Verification
The properties check every cycle that pacing off forces the ready line high. They also check that the stop and go comparisons drive the line the right way, that the band between the levels holds its value, and that a blocked level write leaves the level byte unchanged. On the flag side, they check that a match sets the flag and that the flag holds or clears as required.

Only the bench scenarios show the end-to-end effects. One is that a blocked level write changes later pacing behaviour, seen at the ready line. Others are the nibble order and the scaling by four of the packed level byte, the priority of the stop condition when the levels are set in the wrong order, and a match and a clear landing in the same cycle.

// File: rtl/rxp_pkg.sv
// Package: shared types of the receive flow-control threshold unit.
// Assumes: the control word occupies the low bits of the write data bus.
package rxp_pkg;

    // Configuration addresses seen on the write port
    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LEVEL = 2'd1,
        ADDR_MATCH = 2'd2,
        ADDR_NONE  = 2'd3
    } rxp_addr_e;

    // Control word; last member is bit 0
    typedef struct packed {
        logic spc_det;   // bit 3: match-character detection
        logic auto_rts;  // bit 2: automatic pacing
        logic lvl_mode;  // bit 1: level-byte unlock
        logic enh;       // bit 0: feature unlock
    } rxp_ctrl_t;

    localparam int CTRL_W = $bits(rxp_ctrl_t);

endpackage

// File: rtl/rxp_cfg_regs.sv
// Module: rxp_cfg_regs
// Holds the control word, the packed level byte and the match character.
// The level byte accepts a write only while both unlock bits are set.
// Assumes: DATA_W == 2*LVL_W and DATA_W >= CTRL_W.
module rxp_cfg_regs
    import rxp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rxp_ctrl_t         ctrl_q,
    output logic [DATA_W-1:0] level_q,
    output logic [DATA_W-1:0] match_q,
    output logic [LVL_W-1:0]  halt_fld,
    output logic [LVL_W-1:0]  resume_fld
);

    logic lvl_unlocked;

    // Level byte is writable only with both unlock bits set
    assign lvl_unlocked = ctrl_q.enh & ctrl_q.lvl_mode;

    // Register update on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            level_q <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            case (rxp_addr_e'(wr_addr))
                ADDR_CTRL:  ctrl_q <= rxp_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_LEVEL: if (lvl_unlocked) level_q <= wr_data;
                ADDR_MATCH: match_q <= wr_data;
                default:    ;
            endcase
        end
    end

    // Field split: stop level in the low nibble, go level in the high nibble
    assign halt_fld   = level_q[LVL_W-1:0];
    assign resume_fld = level_q[2*LVL_W-1:LVL_W];

endmodule

// File: rtl/rxp_rts_hyst.sv
// Module: rxp_rts_hyst
// Hysteresis pacing: drops ready at or above the stop level, raises it
// at or below the go level, and holds it in between. The stop test has
// priority, so levels set in the wrong order still give a defined result.
// Assumes: LVL_W + SCALE_SH <= CNT_W.
module rxp_rts_hyst #(
    parameter int CNT_W    = 7,
    parameter int LVL_W    = 4,
    parameter int SCALE_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [LVL_W-1:0] halt_fld,
    input  logic [LVL_W-1:0] resume_fld,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             rts_ready
);

    localparam int LB_W  = LVL_W + SCALE_SH;
    localparam int N_LVL = 2;

    logic [LVL_W-1:0] fld   [N_LVL];
    logic [CNT_W-1:0] lvl_b [N_LVL];
    logic             stop_hit, go_hit;

    assign fld[0] = halt_fld;
    assign fld[1] = resume_fld;

    // Scale each field to a byte count by a left shift
    for (genvar i = 0; i < N_LVL; i++) begin : g_scale
        assign lvl_b[i] = CNT_W'({fld[i], {SCALE_SH{1'b0}}});
    end

    // Threshold comparisons
    assign stop_hit = (fill_cnt >= lvl_b[0]);
    assign go_hit   = (fill_cnt <= lvl_b[1]);

    // Ready line state: forced high when pacing is off, stop has priority
    always_ff @(posedge clk) begin
        if (!rst_n)        rts_ready <= 1'b1;
        else if (!auto_en) rts_ready <= 1'b1;
        else if (stop_hit) rts_ready <= 1'b0;
        else if (go_hit)   rts_ready <= 1'b1;
    end

    if (LB_W > CNT_W) begin : g_bad_width
        initial $error("rxp_rts_hyst: scaled level wider than fill count");
    end

endmodule

// File: rtl/rxp_spc_match.sv
// Module: rxp_spc_match
// Compares each received byte with the match character and keeps a
// sticky flag. A set beats a clear that arrives in the same cycle.
// Assumes: rx_valid is a one-cycle strobe per received byte.
module rxp_spc_match #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_en,
    input  logic [DATA_W-1:0] match_chr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              spc_clr,
    output logic              spc_irq
);

    logic hit;

    // Match event for this cycle
    assign hit = rx_valid & det_en & (rx_byte == match_chr);

    // Sticky flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       spc_irq <= 1'b0;
        else if (hit)     spc_irq <= 1'b1;
        else if (spc_clr) spc_irq <= 1'b0;
    end

endmodule

// File: rtl/rx_pace_unit.sv
// Module: rx_pace_unit (top)
// Receive flow-control threshold unit: configuration registers,
// hysteresis pacing of the ready line and match-character flag.
// Assumes: fill_cnt is the synchronous occupancy of the receive FIFO.
module rx_pace_unit
    import rxp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 7,
    parameter int SCALE_SH = 2,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  fill_cnt,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              spc_clr,
    output logic              rts_ready,
    output logic              spc_irq
);

    localparam int LVL_W = DATA_W / 2;

    rxp_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] level_q;
    logic [DATA_W-1:0] match_q;
    logic [LVL_W-1:0]  halt_fld;
    logic [LVL_W-1:0]  resume_fld;

    rxp_cfg_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q),
        .level_q    (level_q),
        .match_q    (match_q),
        .halt_fld   (halt_fld),
        .resume_fld (resume_fld)
    );

    rxp_rts_hyst #(.CNT_W(CNT_W), .LVL_W(LVL_W), .SCALE_SH(SCALE_SH)) u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (ctrl_q.auto_rts),
        .halt_fld   (halt_fld),
        .resume_fld (resume_fld),
        .fill_cnt   (fill_cnt),
        .rts_ready  (rts_ready)
    );

    rxp_spc_match #(.DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_en    (ctrl_q.spc_det),
        .match_chr (match_q),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .spc_clr   (spc_clr),
        .spc_irq   (spc_irq)
    );

endmodule

// File: rtl/rxp_checker.sv
// Module: rxp_checker
// Cycle properties of the threshold unit, bound into rx_pace_unit.
module rxp_checker
    import rxp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 7,
    parameter int SCALE_SH = 2,
    parameter int ADDR_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              spc_clr,
    input logic              rts_ready,
    input logic              spc_irq,
    input rxp_ctrl_t         ctrl_q,
    input logic [DATA_W-1:0] level_q,
    input logic [DATA_W-1:0] match_q
);

    localparam int LVL_W = DATA_W / 2;

    logic [CNT_W-1:0] stop_b, go_b;
    logic             match_ev;

    // Byte levels as stated by R10
    assign stop_b   = CNT_W'({level_q[LVL_W-1:0], {SCALE_SH{1'b0}}});
    assign go_b     = CNT_W'({level_q[DATA_W-1:LVL_W], {SCALE_SH{1'b0}}});
    assign match_ev = rx_valid && ctrl_q.spc_det && (rx_byte == match_q);

    p_level_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1) && !(ctrl_q.enh && ctrl_q.lvl_mode))
        |=> $stable(level_q));

    p_forced_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.auto_rts |=> rts_ready);

    p_stop_r4_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.auto_rts && fill_cnt >= stop_b) |=> !rts_ready);

    p_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.auto_rts && fill_cnt < stop_b && fill_cnt <= go_b) |=> rts_ready);

    p_band_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.auto_rts && fill_cnt < stop_b && fill_cnt > go_b) |=> $stable(rts_ready));

    p_match_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev |=> spc_irq);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!spc_irq && !match_ev) |=> !spc_irq);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_irq && !spc_clr) |=> spc_irq);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_clr && !match_ev) |=> !spc_irq);

endmodule

bind rx_pace_unit rxp_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SCALE_SH(SCALE_SH), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .fill_cnt  (fill_cnt),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .spc_clr   (spc_clr),
    .rts_ready (rts_ready),
    .spc_irq   (spc_irq),
    .ctrl_q    (ctrl_q),
    .level_q   (level_q),
    .match_q   (match_q)
);

// File: tb/sim_rx_pace_unit.sv
// Scoreboard bench: the driver predicts outputs and queues them,
// the monitor pops and compares one entry after every clock edge.
module sim_rx_pace_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] fill_cnt = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       spc_clr = 1'b0;
    logic       rts_ready, spc_irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Expected-result queues
    bit    exp_rts_q[$];
    bit    exp_irq_q[$];
    string tag_q[$];

    // Reference state built from the requirements
    bit       m_enh = 0, m_mode = 0, m_auto = 0, m_spen = 0;
    bit [7:0] m_lvl = 0, m_chr = 0;
    bit       m_rts = 1, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pace_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fill_cnt(fill_cnt), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .spc_clr(spc_clr), .rts_ready(rts_ready),
        .spc_irq(spc_irq)
    );

    // Driver: one cycle of stimulus plus the predicted result
    task automatic cyc(input bit we, input bit [1:0] a, input bit [7:0] d,
                       input bit [6:0] f, input bit rv, input bit [7:0] rb,
                       input bit clr, input string tag);
        int stop_b, go_b;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; fill_cnt = f;
        rx_valid = rv; rx_byte = rb; spc_clr = clr;
        stop_b = int'(m_lvl[3:0]) * 4;   // R10 low nibble stop level
        go_b   = int'(m_lvl[7:4]) * 4;   // R10 high nibble go level
        if (!m_auto)             m_rts = 1;
        else if (int'(f) >= stop_b) m_rts = 0;
        else if (int'(f) <= go_b)   m_rts = 1;
        if (rv && m_spen && rb == m_chr) m_irq = 1;
        else if (clr)                    m_irq = 0;
        if (we) begin
            case (a)
                2'd0: begin m_enh = d[0]; m_mode = d[1]; m_auto = d[2]; m_spen = d[3]; end
                2'd1: if (m_enh && m_mode) m_lvl = d;
                2'd2: m_chr = d;
                default: ;
            endcase
        end
        exp_rts_q.push_back(m_rts);
        exp_irq_q.push_back(m_irq);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare shortly after each edge
    always @(posedge clk) begin
        #1;
        if (tag_q.size() > 0) begin
            bit er, ei;
            string t;
            er = exp_rts_q.pop_front();
            ei = exp_irq_q.pop_front();
            t  = tag_q.pop_front();
            vectors++;
            if (rts_ready !== er || spc_irq !== ei) begin
                miscompares++;
                $display("FAIL %s: rts_ready=%0b spc_irq=%0b expected rts_ready=%0b spc_irq=%0b",
                         t, rts_ready, spc_irq, er, ei);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        vectors++;
        if (rts_ready !== 1'b1 || spc_irq !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: rts_ready=%0b spc_irq=%0b expected 1 0", rts_ready, spc_irq);
        end
        rst_n = 1'b1;
        cyc(0, 0, 0, 7'd64, 0, 0, 0, "R1");
        cyc(0, 0, 0, 7'd64, 0, 0, 0, "R3 pacing off, full FIFO");
        // R2: only feature unlock set, level write must be dropped
        cyc(1, 0, 8'h01, 7'd0, 0, 0, 0, "R2");
        cyc(1, 1, 8'h2A, 7'd0, 0, 0, 0, "R2 blocked level write");
        cyc(1, 3, 8'hFF, 7'd0, 0, 0, 0, "R2 unused address");
        cyc(1, 0, 8'h05, 7'd0, 0, 0, 0, "R2 pacing on");
        cyc(0, 0, 0, 7'd0, 0, 0, 0, "R2 stop level still 0");
        // R2 accepted write; R10 stop 40, go 8
        cyc(1, 0, 8'h07, 7'd0, 0, 0, 0, "R2");
        cyc(1, 1, 8'h2A, 7'd0, 0, 0, 0, "R2 unlocked level write");
        cyc(0, 0, 0, 7'd8,  0, 0, 0, "R5 R10 at go level");
        cyc(0, 0, 0, 7'd39, 0, 0, 0, "R6 band holds high");
        cyc(0, 0, 0, 7'd40, 0, 0, 0, "R4 R10 at stop level");
        cyc(0, 0, 0, 7'd20, 0, 0, 0, "R6 band holds low");
        cyc(0, 0, 0, 7'd9,  0, 0, 0, "R6 just above go");
        cyc(0, 0, 0, 7'd8,  0, 0, 0, "R5 back to go");
        cyc(0, 0, 0, 7'd64, 0, 0, 0, "R4 full FIFO");
        // R7 reversed or equal levels
        cyc(1, 1, 8'h55, 7'd0,  0, 0, 0, "R7 equal levels 20");
        cyc(0, 0, 0, 7'd20, 0, 0, 0, "R7 both true, stop wins");
        cyc(0, 0, 0, 7'd19, 0, 0, 0, "R7 below stop");
        cyc(1, 1, 8'h83, 7'd0,  0, 0, 0, "R7 stop 12 go 32");
        cyc(0, 0, 0, 7'd12, 0, 0, 0, "R7 at stop");
        cyc(0, 0, 0, 7'd30, 0, 0, 0, "R7 overlap stays low");
        cyc(0, 0, 0, 7'd5,  0, 0, 0, "R7 below stop, go");
        cyc(0, 0, 0, 7'd40, 0, 0, 0, "R7 above stop");
        cyc(1, 0, 8'h03, 7'd64, 0, 0, 0, "R3 pacing turned off");
        cyc(0, 0, 0, 7'd64, 0, 0, 0, "R3 forced ready");
        // R8 and R9 match flag
        cyc(1, 2, 8'h13, 7'd0, 0, 0, 0, "R8 set char");
        cyc(0, 0, 0, 7'd0, 1, 8'h13, 0, "R8 detect off");
        cyc(1, 0, 8'h0B, 7'd0, 0, 0, 0, "R8 detect on");
        cyc(0, 0, 0, 7'd0, 1, 8'h12, 0, "R8 non-match");
        cyc(0, 0, 0, 7'd0, 0, 8'h13, 0, "R8 no strobe");
        cyc(0, 0, 0, 7'd0, 1, 8'h13, 0, "R8 match");
        cyc(0, 0, 0, 7'd0, 0, 0, 0, "R9 sticky");
        cyc(0, 0, 0, 7'd0, 0, 0, 1, "R9 clear");
        cyc(0, 0, 0, 7'd0, 1, 8'h13, 1, "R9 set beats clear");
        cyc(0, 0, 0, 7'd0, 0, 0, 1, "R9 clear again");
        cyc(0, 0, 0, 7'd0, 0, 0, 0, "R9 stays clear");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule